// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O controller reached through a simple word-wide register bus. There is one bit per pin in every register. Software sets each pin's direction. It drives outputs through write-one-to-set and write-one-to-clear registers, so it never needs a read-modify-write. It reads the synchronized input levels.

Every pin can raise an interrupt. Three independent per-pin configuration bits select the trigger: level against edge, single against both edges, and polarity. Detected events latch into a raw status register whether or not the pin's interrupt is enabled. The raw status ANDed with an enable mask gives the masked status. Any masked bit set drives a single active-high interrupt line.

Pad inputs pass through a two-stage synchronizer before they are read or used for detection. Bus writes take effect at the clock edge. Reads are combinational from the current address. The address is a 4-bit word index.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low, so every pin is an input with interrupts disabled.
- R2: The direction register at word index 0 is read/write. A bit of 1 makes the pin an output (`pin_oe` bit 1) and a bit of 0 makes it an input.
- R3: Writing index 2 sets every output bit whose written bit is 1, and writing index 3 clears every such bit. Bits written 0 keep their value. Index 1 reads back the driven values, which also appear on `pin_out`.
- R4: Index 4 returns the pad levels after a two-flop synchronizer: a change on `pin_in` is visible there after the second rising clock edge.
- R5: With the trigger-type bit (index 5) at 1, the pin is level sensed. The polarity bit (index 7) at 0 means active high and at 1 means active low. The raw status bit (index 9) sets while the level is active.
- R6: With trigger-type 0 and the edge-both bit (index 6) at 0, the pin latches on a rising edge when polarity is 0 and on a falling edge when polarity is 1. The opposite edge latches nothing.
- R7: With trigger-type 0 and edge-both 1, the pin latches on both rising and falling edges, whatever its polarity bit.
- R8: Writing 1s to the interrupt-clear register (index 11) clears those raw bits, and bits written 0 are untouched. A new event in the same cycle wins over the clear, so a level source that is still active reads back as set.
- R9: The masked status (index 10) reads raw status AND the enable register (index 8). Events latch into raw status even while their enable bit is 0.
- R10: `irq` is high exactly when some masked status bit is set.
- R11: The write-only indices 2, 3 and 11 and the unmapped indices 12 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Aggregated interrupt, active high |

## Verification
The bench aims at the polarity decode of single-edge mode. A design that swapped the meaning of the polarity bit would latch a rising edge on a falling-configured pin, and the bench reads that back as a spurious raw bit. It clears an active-low level source while that level is still active and expects the bit to stay set. A clear that beat the event would wrongly read 0 there and would lose still-pending requests. It also latches an edge with the enable at 0 and enables it later. A design that gated latching with the enable would never raise `irq` at that point. Finally, it samples the input register one edge too early and at the right edge, which catches a synchronizer with the wrong depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] REG_DIR  = 4'd0;
  localparam logic [ADDR_W-1:0] REG_DOUT = 4'd1;
  localparam logic [ADDR_W-1:0] REG_SET  = 4'd2;
  localparam logic [ADDR_W-1:0] REG_CLR  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_DIN  = 4'd4;
  localparam logic [ADDR_W-1:0] REG_TRIG = 4'd5;
  localparam logic [ADDR_W-1:0] REG_BOTH = 4'd6;
  localparam logic [ADDR_W-1:0] REG_POL  = 4'd7;
  localparam logic [ADDR_W-1:0] REG_EN   = 4'd8;
  localparam logic [ADDR_W-1:0] REG_RAW  = 4'd9;
  localparam logic [ADDR_W-1:0] REG_MSK  = 4'd10;
  localparam logic [ADDR_W-1:0] REG_ICLR = 4'd11;

  // Edge decision for one pin: cur/prev are consecutive synchronized samples.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic both, input logic pol);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    return pol ? fall : rise;
  endfunction

  // Level decision: active high when pol is 0, active low when pol is 1.
  function automatic logic level_hit(input logic cur, input logic pol);
    return cur ^ pol;
  endfunction

  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic level, input logic both,
                                     input logic pol);
    return level ? level_hit(cur, pol) : edge_hit(cur, prev, both, pol);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] cfg_level,
  input  logic [N-1:0] cfg_both,
  input  logic [N-1:0] cfg_pol,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] evt,
  output logic [N-1:0] raw_q
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign evt[g] = pin_event(cur[g], prev_q[g], cfg_level[g], cfg_both[g], cfg_pol[g]);
  end

  // A fresh event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= cur;
      raw_q  <= (raw_q & ~clr_mask) | evt;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      din,
  input  logic [N-1:0]      raw,
  input  logic [N-1:0]      masked,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      dout_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      clr_mask
);
  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;

  assign set_bits = (bus_we && bus_addr == REG_SET)  ? bus_wdata : '0;
  assign clr_bits = (bus_we && bus_addr == REG_CLR)  ? bus_wdata : '0;
  assign clr_mask = (bus_we && bus_addr == REG_ICLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      trig_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      dout_q <= (dout_q | set_bits) & ~clr_bits;
      if (bus_we) begin
        case (bus_addr)
          REG_DIR:  dir_q  <= bus_wdata;
          REG_TRIG: trig_q <= bus_wdata;
          REG_BOTH: both_q <= bus_wdata;
          REG_POL:  pol_q  <= bus_wdata;
          REG_EN:   en_q   <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      REG_DIR:  bus_rdata = dir_q;
      REG_DOUT: bus_rdata = dout_q;
      REG_DIN:  bus_rdata = din;
      REG_TRIG: bus_rdata = trig_q;
      REG_BOTH: bus_rdata = both_q;
      REG_POL:  bus_rdata = pol_q;
      REG_EN:   bus_rdata = en_q;
      REG_RAW:  bus_rdata = raw;
      REG_MSK:  bus_rdata = masked;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0] din_s;
  logic [N-1:0] evt;
  logic [N-1:0] raw_q;
  logic [N-1:0] masked;
  logic [N-1:0] dir_q, dout_q, trig_q, both_q, pol_q, en_q, clr_mask;

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s)
  );

  gpio_evt_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .cur(din_s),
    .cfg_level(trig_q), .cfg_both(both_q), .cfg_pol(pol_q),
    .clr_mask(clr_mask), .evt(evt), .raw_q(raw_q)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din_s),
    .raw(raw_q), .masked(masked), .dir_q(dir_q), .dout_q(dout_q),
    .trig_q(trig_q), .both_q(both_q), .pol_q(pol_q), .en_q(en_q),
    .clr_mask(clr_mask)
  );

  assign masked  = raw_q & en_q;
  assign irq     = |masked;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      pin_out,
  input logic              irq,
  input logic [N-1:0]      raw,
  input logic [N-1:0]      en,
  input logic [N-1:0]      evt
);
  logic [N-1:0] clr_req;
  assign clr_req = (bus_we && bus_addr == REG_ICLR) ? bus_wdata : '0;

  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

  a_r8_raw_rises_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~$past(raw) & ~$past(evt)) == '0));

  a_r8_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & $past(clr_req) & ~$past(evt)) == '0));

  a_r10_irq_tracks_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw & en) != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N(N)) u_gpio_irq_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .irq(irq),
  .raw(raw_q), .en(en_q), .evt(evt)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Drive pads at a falling edge and wait until raw status can reflect them.
  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 dir", 4'd0, 32'h0);
    expect_reg("R1 dout", 4'd1, 32'h0);
    expect_reg("R1 trig", 4'd5, 32'h0);
    expect_reg("R1 en", 4'd8, 32'h0);
    expect_reg("R1 raw", 4'd9, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_direction();
    wr(4'd0, 32'hA5A5_0F0F);
    expect_reg("R2 dir readback", 4'd0, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
  endtask

  task automatic t_set_clr();
    wr(4'd2, 32'h0000_00F0);
    expect_reg("R3 set", 4'd1, 32'h0000_00F0);
    wr(4'd2, 32'h0000_0003);
    expect_reg("R3 set keeps zeros", 4'd1, 32'h0000_00F3);
    wr(4'd3, 32'h0000_0030);
    expect_reg("R3 clr", 4'd1, 32'h0000_00C3);
    check("R3 pin_out", pin_out, 32'h0000_00C3);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    rd(4'd4, d);
    check("R4 not yet visible", d, 32'h0);
    @(negedge clk);
    rd(4'd4, d);
    check("R4 visible after two edges", d, 32'h1234_5678);
  endtask

  task automatic t_level();
    drive_pins(32'h0);
    repeat (2) @(negedge clk);
    wr(4'd5, 32'h0000_0003);
    wr(4'd7, 32'h0000_0002);
    wr(4'd11, 32'hFFFF_FFFF);
    expect_reg("R8 active-low level re-latches after clear", 4'd9, 32'h0000_0002);
    drive_pins(32'h0000_0001);
    expect_reg("R5 active-high level", 4'd9, 32'h0000_0003);
    drive_pins(32'h0000_0003);
    wr(4'd11, 32'h0000_0002);
    expect_reg("R8 clear of inactive level", 4'd9, 32'h0000_0001);
    wr(4'd11, 32'h0);
    expect_reg("R8 zero bits untouched", 4'd9, 32'h0000_0001);
  endtask

  task automatic t_edge();
    wr(4'd5, 32'h0);
    drive_pins(32'h0);
    wr(4'd11, 32'hFFFF_FFFF);
    expect_reg("R6 cleared", 4'd9, 32'h0);
    drive_pins(32'h0000_0010);
    expect_reg("R6 rising latched", 4'd9, 32'h0000_0010);
    wr(4'd11, 32'h0000_0010);
    drive_pins(32'h0);
    expect_reg("R6 falling ignored on rising pin", 4'd9, 32'h0);
    wr(4'd7, 32'h0000_0020);
    drive_pins(32'h0000_0020);
    expect_reg("R6 rising ignored on falling pin", 4'd9, 32'h0);
    drive_pins(32'h0);
    expect_reg("R6 falling latched", 4'd9, 32'h0000_0020);
    wr(4'd11, 32'hFFFF_FFFF);
  endtask

  task automatic t_both();
    wr(4'd6, 32'h0000_0040);
    drive_pins(32'h0000_0040);
    expect_reg("R7 rise latched", 4'd9, 32'h0000_0040);
    wr(4'd11, 32'h0000_0040);
    expect_reg("R7 cleared", 4'd9, 32'h0);
    drive_pins(32'h0);
    expect_reg("R7 fall latched", 4'd9, 32'h0000_0040);
  endtask

  task automatic t_mask();
    expect_reg("R9 masked zero while disabled", 4'd10, 32'h0);
    check("R10 irq low while disabled", {31'h0, irq}, 32'h0);
    wr(4'd8, 32'h0000_0040);
    expect_reg("R9 pending event revealed", 4'd10, 32'h0000_0040);
    check("R10 irq high", {31'h0, irq}, 32'h1);
    wr(4'd11, 32'h0000_0040);
    check("R10 irq low after clear", {31'h0, irq}, 32'h0);
    wr(4'd8, 32'hFFFF_FFFF);
    expect_reg("R9 enabled but no status", 4'd10, 32'h0);
    check("R10 irq low with empty status", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_readonly_zero();
    expect_reg("R11 set reads zero", 4'd2, 32'h0);
    expect_reg("R11 clr reads zero", 4'd3, 32'h0);
    expect_reg("R11 iclr reads zero", 4'd11, 32'h0);
    expect_reg("R11 unmapped reads zero", 4'd15, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_set_clr();
    t_sync();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_readonly_zero();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule